// File: doc/BRIEF.md
# Program End Detector with Periodic Publication

This block sits beside the execute stage of a simple 32-bit load/store processor. On every instruction step it compares the executed instruction word with two fixed end-of-program idioms. The first idiom is an equality branch that compares register 0 with itself and jumps to itself. The second is a jump through the link register, taken while that register holds zero. A hit sets an internal halt flag. Only reset or a new program start clears this flag.

The flag drives a write gate straight away. That gate is low in the cycle of the ending instruction itself, so the ending instruction commits nothing. It stays low on every later cycle, so register-file and memory updates stop and the machine state stays frozen. The outside world sees the end only at coarse intervals. A counter of steps runs modulo a configurable period C. Each time it wraps, the block pulses a publish strobe and copies the flag into a done flag that stays set. Up to C−1 steps can therefore run after the end before it is published, and those steps leave the state unchanged.

Top module: `term_watch`

## Requirements
- R1: During and after synchronous active-low reset, with no step, `wr_gate_o` is 1, `reveal_o` is 0 and `done_o` is 0.
- R2: A step whose instruction word is exactly 32'h1000FFFF drives `wr_gate_o` to 0 in that same cycle. This word is opcode 6'h04 in bits [31:26], rs=0, rt=0 and immediate 16'hFFFF.
- R3: A step whose word is exactly 32'h03E00008 halts only when `link_val_i` is zero. This word is opcode 0, rs=31 in bits [25:21], rt=rd=shamt=0 and funct 6'h08. With a nonzero link value it has no effect on `wr_gate_o`.
- R4: Words that differ from the two idioms in any bit do not halt, for example 32'h1000FFFE, 32'h1021FFFF and 32'h03E00009.
- R5: An idiom word presented while `step_i` is 0 has no effect on `wr_gate_o` or `done_o`.
- R6: After a halt, `wr_gate_o` stays 0 on every later cycle, whatever the instruction, until `start_i` or reset.
- R7: `reveal_o` is a one-cycle pulse in the cycle after every C-th step counted since reset or the last `start_i` (C = `REVEAL_PERIOD`).
- R8: `done_o` rises only together with a `reveal_o` pulse, and only if a halt occurred at or before the wrapping step. It then stays 1 until `start_i` or reset.
- R9: A `start_i` pulse clears the halt flag, `done_o` and the step count, so the next reveal follows the C-th step after it.
- R10: Cycles without `step_i` do not advance the step count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Program-start pulse; clears halt, done and count |
| step_i | input | 1 | An instruction executes this cycle |
| instr_i | input | 32 | Word of the executing instruction |
| link_val_i | input | DATA_W | Current value of register 31 |
| wr_gate_o | output | 1 | 1 = register and memory writes allowed |
| reveal_o | output | 1 | Publish strobe at each count wrap |
| done_o | output | 1 | Published, sticky end-of-program flag |

## Verification
The properties assume that `start_i` and `step_i` are never high in the same cycle, and that `start_i` is a single-cycle pulse issued between programs. The stimulus holds every instruction, link value and strobe stable from one falling edge to the next. It raises `start_i` only on cycles with no step. Word patterns are the exact idioms, near-miss words, and idioms shown without a step. Halts are placed both before and between publication points.

// File: rtl/term_watch_pkg.sv
// Shared field layout and idiom constants for the end-of-program detector.
// Assumes a fixed 32-bit three-register instruction format.
package term_watch_pkg;

    localparam int INSTR_W = 32;

    typedef struct packed {
        logic [5:0] opcode;
        logic [4:0] rs;
        logic [4:0] rt;
        logic [4:0] rd;
        logic [4:0] shamt;
        logic [5:0] funct;
    } ins_fields_t;

    localparam logic [5:0]  OPC_SPECIAL = 6'h00;
    localparam logic [5:0]  OPC_BREQ    = 6'h04;
    localparam logic [5:0]  FN_JUMPREG  = 6'h08;
    localparam logic [4:0]  REG_ZERO    = 5'd0;
    localparam logic [4:0]  REG_LINK    = 5'd31;
    localparam logic [15:0] OFS_SELF    = 16'hFFFF;

endpackage

// File: rtl/term_decode.sv
// Combinational matcher for the two end-of-program idioms.
// Assumes instr_i is the word executing this cycle and link_i is register 31.
module term_decode
    import term_watch_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [INSTR_W-1:0] instr_i,
    input  logic [DATA_W-1:0]  link_i,
    output logic               hit_o
);

    ins_fields_t f;
    logic        self_branch;
    logic        link_jump;

    // Split the word into fields and test both idioms.
    always_comb begin
        f           = ins_fields_t'(instr_i);
        self_branch = (f.opcode == OPC_BREQ) && (f.rs == REG_ZERO) &&
                      (f.rt == REG_ZERO) && ({f.rd, f.shamt, f.funct} == OFS_SELF);
        link_jump   = (f.opcode == OPC_SPECIAL) && (f.rs == REG_LINK) &&
                      (f.rt == REG_ZERO) && (f.rd == REG_ZERO) &&
                      (f.shamt == 5'd0) && (f.funct == FN_JUMPREG) &&
                      (link_i == '0);
        hit_o       = self_branch || link_jump;
    end

endmodule

// File: rtl/halt_latch.sv
// Sticky halt flag: set by a qualified hit, cleared by reset or clear.
// Assumes clr_i and set_i are not raised together by the user.
module halt_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic set_i,
    output logic halted_o
);

    // Hold the flag once set, clear has priority.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) halted_o <= 1'b0;
        else if (set_i)      halted_o <= 1'b1;
    end

    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (halted_o && !clr_i) |=> halted_o);

endmodule

// File: rtl/reveal_timer.sv
// Step counter modulo PERIOD; flags the step that completes a period.
// Assumes adv_i is high for exactly one cycle per executed instruction.
module reveal_timer #(
    parameter int PERIOD = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic adv_i,
    output logic wrap_o
);

    localparam int                 CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CNT_W-1:0]   LAST  = CNT_W'(PERIOD - 1);

    logic [CNT_W-1:0] cnt_q;

    // Current step completes a period.
    assign wrap_o = adv_i && (cnt_q == LAST);

    // Advance on each step, wrap at the period end.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) cnt_q <= '0;
        else if (wrap_o)     cnt_q <= '0;
        else if (adv_i)      cnt_q <= cnt_q + 1'b1;
    end

    p_cnt_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_i && !clr_i) |=> $stable(cnt_q));

endmodule

// File: rtl/term_watch.sv
// End-of-program detector with immediate write gating and publication
// every REVEAL_PERIOD steps. Assumes start_i never coincides with step_i.
module term_watch
    import term_watch_pkg::*;
#(
    parameter int DATA_W        = 32,
    parameter int REVEAL_PERIOD = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               step_i,
    input  logic [INSTR_W-1:0] instr_i,
    input  logic [DATA_W-1:0]  link_val_i,
    output logic               wr_gate_o,
    output logic               reveal_o,
    output logic               done_o
);

    logic idiom_hit;
    logic hit_now;
    logic halted_q;
    logic wrap_now;

    term_decode #(.DATA_W(DATA_W)) u_decode (
        .instr_i (instr_i),
        .link_i  (link_val_i),
        .hit_o   (idiom_hit)
    );

    assign hit_now = step_i && idiom_hit;

    halt_latch u_halt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (start_i),
        .set_i    (hit_now),
        .halted_o (halted_q)
    );

    reveal_timer #(.PERIOD(REVEAL_PERIOD)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (start_i),
        .adv_i  (step_i),
        .wrap_o (wrap_now)
    );

    // Block writes from the ending instruction onward.
    assign wr_gate_o = !(halted_q || hit_now);

    // Publish strobe and sticky done flag, updated at each wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || start_i) begin
            reveal_o <= 1'b0;
            done_o   <= 1'b0;
        end else begin
            reveal_o <= wrap_now;
            if (wrap_now) done_o <= done_o || halted_q || hit_now;
        end
    end

    p_gate_closed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        halted_q |-> !wr_gate_o);
    p_reveal_follows_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reveal_o |-> $past(step_i));
    p_done_on_reveal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> reveal_o);
    p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);
    p_done_implies_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> halted_q);

endmodule

// File: tb/term_watch_tb.sv
// Scoreboard bench: the driver predicts each cycle, the monitor compares.
module term_watch_tb;

    localparam int         C      = 8;
    localparam int         DW     = 32;
    localparam time        CLK_P  = 4ns;
    localparam logic [31:0] W_SELF = 32'h1000FFFF;
    localparam logic [31:0] W_JRRA = 32'h03E00008;
    localparam logic [31:0] W_NOP  = 32'h00000000;

    typedef struct {
        logic  gate;
        logic  rev;
        logic  done;
        string tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          step_i = 1'b0;
    logic [31:0]   instr_i = '0;
    logic [DW-1:0] link_val_i = '0;
    logic          wr_gate_o, reveal_o, done_o;

    int   checks = 0;
    int   errors = 0;
    exp_t q[$];

    // model state, built from the requirements
    logic m_halt = 1'b0;
    logic m_done = 1'b0;
    int   m_cnt  = 0;

    always #(CLK_P/2) clk = ~clk;

    term_watch #(.DATA_W(DW), .REVEAL_PERIOD(C)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .step_i(step_i),
        .instr_i(instr_i), .link_val_i(link_val_i),
        .wr_gate_o(wr_gate_o), .reveal_o(reveal_o), .done_o(done_o)
    );

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: %s actual %0b expected %0b", tag, what, act, exp);
        end
    endtask

    // One cycle of stimulus plus its predicted outcome.
    task automatic drive(input logic st, input logic stp, input logic [31:0] w,
                         input logic [DW-1:0] lv, input string tag);
        exp_t e;
        logic hit, wrap;
        @(negedge clk);
        start_i = st; step_i = stp; instr_i = w; link_val_i = lv;
        hit    = stp && ((w == W_SELF) || (w == W_JRRA && lv == '0));
        e.gate = !(m_halt || hit);
        e.tag  = tag;
        if (st) begin
            m_halt = 1'b0; m_done = 1'b0; m_cnt = 0; e.rev = 1'b0;
        end else begin
            wrap   = stp && (m_cnt == C - 1);
            e.rev  = wrap;
            if (wrap) m_done = m_done || m_halt || hit;
            if (hit)  m_halt = 1'b1;
            if (stp)  m_cnt  = wrap ? 0 : m_cnt + 1;
        end
        e.done = m_done;
        q.push_back(e);
    endtask

    task automatic steps(input int n, input logic [31:0] w, input string tag);
        for (int i = 0; i < n; i++) drive(1'b0, 1'b1, w, 32'd7, tag);
    endtask

    // Monitor: pops one prediction per driven cycle.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                logic g;
                e = q.pop_front();
                g = wr_gate_o;
                @(posedge clk);
                #1;
                check(e.tag, "wr_gate_o", g, e.gate);
                check(e.tag, "reveal_o", reveal_o, e.rev);
                check(e.tag, "done_o", done_o, e.done);
            end
        end
    end

    initial begin
        #(CLK_P * 200000);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R1", "wr_gate_o", wr_gate_o, 1'b1);
        check("R1", "reveal_o", reveal_o, 1'b0);
        check("R1", "done_o", done_o, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        drive(1'b0, 1'b0, W_NOP, 32'd0, "R1");
        drive(1'b1, 1'b0, W_NOP, 32'd0, "R9");
        steps(2, W_NOP, "R7");
        drive(1'b0, 1'b1, W_JRRA, 32'd5, "R3");
        drive(1'b0, 1'b1, 32'h1000FFFE, 32'd0, "R4");
        drive(1'b0, 1'b1, 32'h1021FFFF, 32'd0, "R4");
        drive(1'b0, 1'b1, 32'h03E00009, 32'd0, "R4");
        drive(1'b0, 1'b0, W_SELF, 32'd0, "R5");
        drive(1'b0, 1'b0, W_JRRA, 32'd0, "R5");
        drive(1'b0, 1'b0, W_NOP, 32'd0, "R10");
        steps(3, W_NOP, "R7");
        steps(2, W_NOP, "R8");
        drive(1'b0, 1'b1, W_SELF, 32'd9, "R2");
        steps(4, W_NOP, "R6");
        drive(1'b0, 1'b0, W_NOP, 32'd0, "R6");
        steps(4, W_NOP, "R8");
        steps(3, W_NOP, "R8");
        drive(1'b1, 1'b0, W_NOP, 32'd0, "R9");
        steps(3, W_NOP, "R9");
        drive(1'b0, 1'b1, W_JRRA, 32'd0, "R3");
        steps(C + 2, W_NOP, "R8");
        drive(1'b1, 1'b0, W_NOP, 32'd0, "R9");
        steps(C - 1, W_NOP, "R9");
        drive(1'b0, 1'b1, W_SELF, 32'd0, "R8");
        steps(2, W_NOP, "R6");
        drive(1'b0, 1'b0, W_NOP, 32'd0, "R10");
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule